// File: doc/BRIEF.md
# Masked Event Status and Dual Interrupt Unit

This unit is the register front of a card-interface controller. It holds a sticky event-status word that the command and data engines set with one-cycle pulses. Software clears that word through a write-to-clear register. Two independent mask registers each drive their own interrupt line. The engines also supply live FIFO-state flags, which appear in the upper part of the status word without being stored. Their changes therefore reach the read port and the interrupt lines in the same cycle.

The unit also holds a few plain configuration registers: power, clock, argument and command. It keeps four response words that the command engine loads in one cycle. A fixed eight-entry identification table sits at the top of the 4 KiB window. The host port is a simple word-addressed bus. A write takes effect at the next clock edge, and read data is a combinational function of the address. Byte offsets in this brief are divided by four to give the word address.

Top module: `mmc_stat_irq`

## Requirements
- R1: After reset, the power, clock, argument, command, response words, sticky status and both masks read as zero, and both interrupt lines are low.
- R2: A one-cycle pulse on event input bit k (k in 0..8 or 10) sets status bit k at the next edge, and the bit stays set until it is cleared. Status bit 9 never sets and always reads 0.
- R3: A write to byte offset 0x38 clears each status bit in [10:0] whose written data bit is 1. Live bits [21:11] and uncleared sticky bits are unaffected.
- R4: When an event pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R5: A status read at byte offset 0x34 returns the sticky bits in [10:0] and the live flag inputs in [21:11] with live input bit j at status bit 11+j. The live bits follow the inputs in the same cycle, and bits [31:22] read 0.
- R6: Interrupt line A is high exactly when the status word ANDed with the mask at offset 0x3C is nonzero, and line B likewise with the mask at 0x40. Each mask stores bits [21:0] and reads 0 above.
- R7: Power (0x00) and clock (0x04) keep only the low 8 written bits. Argument (0x08) and command (0x0C) keep all 32 bits. All four read back what they hold.
- R8: A pulse on the response-load input copies four 32-bit words into offsets 0x14, 0x18, 0x1C and 0x20, with the word at offset 0x14 taken from input bits [31:0]. Host writes to these offsets have no effect.
- R9: Reads at byte offsets 0xFE0 to 0xFFC return, in address order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R10: Unmapped offsets read 0 and writes to them change nothing. Writes to the status offset are ignored, and the clear offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWordAddr | input | 10 | Word address (byte offset divided by four) |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busWordAddr |
| evtPulse | input | 11 | One-cycle event pulses, bit k sets status bit k |
| liveFlags | input | 11 | Live FIFO and engine state, shown at status [21:11] |
| rspLoad | input | 1 | Load strobe for the response words |
| rspWords | input | 128 | Four response words, word 0 in the low 32 bits |
| intReqA | output | 1 | Interrupt line gated by the first mask |
| intReqB | output | 1 | Interrupt line gated by the second mask |

## Verification
A wrong sticky bit shows up on the first status read after the faulty edge. When the matching mask bit is set, it also shows on an interrupt line in that same cycle, because the lines are pure logic of the stored state. A wrong decode hits a neighbouring register, so every write is followed by reads of both the target offset and an unrelated offset. A reversed priority between set and clear only becomes visible when a pulse and a clear land in one cycle, and the bench creates that collision deliberately.

// File: rtl/mmc_stat_pkg.sv
package mmc_stat_pkg;

  localparam int WADDR_W  = 10;
  localparam int STICKY_W = 11;
  localparam int LIVE_W   = 11;
  localparam int STATUS_W = STICKY_W + LIVE_W;
  localparam int NUM_IRQ  = 2;
  localparam int ID_W     = 8;

  // bit 9 of the event field is a hole that never latches
  localparam logic [STICKY_W-1:0] STICKY_VALID = 11'h5FF;

  localparam logic [WADDR_W-1:0] W_POWER  = 10'd0;
  localparam logic [WADDR_W-1:0] W_CLOCK  = 10'd1;
  localparam logic [WADDR_W-1:0] W_ARG    = 10'd2;
  localparam logic [WADDR_W-1:0] W_CMD    = 10'd3;
  localparam logic [WADDR_W-1:0] W_RSP0   = 10'd5;
  localparam logic [WADDR_W-1:0] W_RSP3   = 10'd8;
  localparam logic [WADDR_W-1:0] W_STATUS = 10'd13;
  localparam logic [WADDR_W-1:0] W_CLEAR  = 10'd14;
  localparam logic [WADDR_W-1:0] W_MASKA  = 10'd15;
  localparam logic [WADDR_W-1:0] W_MASKB  = 10'd16;

  typedef struct packed {
    logic wrPower;
    logic wrClock;
    logic wrArg;
    logic wrCmd;
    logic wrClear;
    logic wrMaskA;
    logic wrMaskB;
  } wrStrobeT;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_POWER,
    SEL_CLOCK,
    SEL_ARG,
    SEL_CMD,
    SEL_RSP,
    SEL_STATUS,
    SEL_MASKA,
    SEL_MASKB,
    SEL_ID
  } rdSelT;

  function automatic logic [ID_W-1:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0:    idByte = 8'h81;
      3'd1:    idByte = 8'h11;
      3'd2:    idByte = 8'h04;
      3'd3:    idByte = 8'h00;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/mmc_stat_ctrl.sv
module mmc_stat_ctrl
  import mmc_stat_pkg::*;
#(
  parameter int NUM_RSP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic               wrEn,
  output wrStrobeT           strb,
  output rdSelT              rdSel,
  output logic [$clog2(NUM_RSP)-1:0] rspIdx,
  output logic [2:0]         idIdx
);

  localparam int RSP_IDX_W = $clog2(NUM_RSP);

  logic inIdWindow;
  logic inRspWindow;
  logic [WADDR_W-1:0] rspOffset;

  assign inIdWindow  = (wordAddr[WADDR_W-1:3] == '1);
  assign inRspWindow = (wordAddr >= W_RSP0) && (wordAddr <= W_RSP3);
  assign rspOffset   = wordAddr - W_RSP0;
  assign rspIdx      = rspOffset[RSP_IDX_W-1:0];
  assign idIdx       = wordAddr[2:0];

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wordAddr)
        W_POWER: strb.wrPower = 1'b1;
        W_CLOCK: strb.wrClock = 1'b1;
        W_ARG:   strb.wrArg   = 1'b1;
        W_CMD:   strb.wrCmd   = 1'b1;
        W_CLEAR: strb.wrClear = 1'b1;
        W_MASKA: strb.wrMaskA = 1'b1;
        W_MASKB: strb.wrMaskB = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (inIdWindow) begin
      rdSel = SEL_ID;
    end else if (inRspWindow) begin
      rdSel = SEL_RSP;
    end else begin
      case (wordAddr)
        W_POWER:  rdSel = SEL_POWER;
        W_CLOCK:  rdSel = SEL_CLOCK;
        W_ARG:    rdSel = SEL_ARG;
        W_CMD:    rdSel = SEL_CMD;
        W_STATUS: rdSel = SEL_STATUS;
        W_MASKA:  rdSel = SEL_MASKA;
        W_MASKB:  rdSel = SEL_MASKB;
        default:  rdSel = SEL_NONE;
      endcase
    end
  end

  // R10: a single write never reaches two registers
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R10: no strobe without a bus write
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0));

endmodule

// File: rtl/mmc_stat_path.sv
module mmc_stat_path
  import mmc_stat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int NUM_RSP  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobeT                  strb,
  input  rdSelT                     rdSel,
  input  logic [$clog2(NUM_RSP)-1:0] rspIdx,
  input  logic [2:0]                idIdx,
  input  logic [DATA_W-1:0]         busWrData,
  input  logic [STICKY_W-1:0]       evtPulse,
  input  logic [LIVE_W-1:0]         liveFlags,
  input  logic                      rspLoad,
  input  logic [NUM_RSP*DATA_W-1:0] rspWords,
  output logic [DATA_W-1:0]         busRdData,
  output logic [NUM_IRQ-1:0]        irqOut
);

  logic [NARROW_W-1:0] powerQ;
  logic [NARROW_W-1:0] clockQ;
  logic [DATA_W-1:0]   argQ;
  logic [DATA_W-1:0]   cmdQ;
  logic [DATA_W-1:0]   rspQ [NUM_RSP];
  logic [STATUS_W-1:0] maskQ [NUM_IRQ];
  logic [STICKY_W-1:0] stickyQ;
  logic [STICKY_W-1:0] setBits;
  logic [STICKY_W-1:0] clrBits;
  logic [STATUS_W-1:0] statusWord;
  logic [NUM_IRQ-1:0]  maskWr;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerQ <= '0;
      clockQ <= '0;
      argQ   <= '0;
      cmdQ   <= '0;
    end else begin
      if (strb.wrPower) powerQ <= busWrData[NARROW_W-1:0];
      if (strb.wrClock) clockQ <= busWrData[NARROW_W-1:0];
      if (strb.wrArg)   argQ   <= busWrData;
      if (strb.wrCmd)   cmdQ   <= busWrData;
    end
  end

  // response words, loaded together by the command engine
  for (genvar r = 0; r < NUM_RSP; r++) begin : gRsp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rspQ[r] <= '0;
      end else if (rspLoad) begin
        rspQ[r] <= rspWords[r*DATA_W +: DATA_W];
      end
    end
  end

  // sticky events: set has priority over clear
  assign setBits = evtPulse & STICKY_VALID;
  assign clrBits = strb.wrClear ? busWrData[STICKY_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
    end else begin
      stickyQ <= (stickyQ & ~clrBits) | setBits;
    end
  end

  assign statusWord = {liveFlags, stickyQ};

  // masks and interrupt lines
  assign maskWr = {strb.wrMaskB, strb.wrMaskA};

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrq
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[g] <= '0;
      end else if (maskWr[g]) begin
        maskQ[g] <= busWrData[STATUS_W-1:0];
      end
    end

    assign irqOut[g] = |(statusWord & maskQ[g]);

    // R6: an empty mask keeps its line quiet
    a_r6_quiet_mask: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[g] == '0) |-> !irqOut[g]);
  end

  // read mux
  always_comb begin
    busRdData = '0;
    case (rdSel)
      SEL_POWER:  busRdData = {{(DATA_W-NARROW_W){1'b0}}, powerQ};
      SEL_CLOCK:  busRdData = {{(DATA_W-NARROW_W){1'b0}}, clockQ};
      SEL_ARG:    busRdData = argQ;
      SEL_CMD:    busRdData = cmdQ;
      SEL_RSP:    busRdData = rspQ[rspIdx];
      SEL_STATUS: busRdData = {{(DATA_W-STATUS_W){1'b0}}, statusWord};
      SEL_MASKA:  busRdData = {{(DATA_W-STATUS_W){1'b0}}, maskQ[0]};
      SEL_MASKB:  busRdData = {{(DATA_W-STATUS_W){1'b0}}, maskQ[1]};
      SEL_ID:     busRdData = {{(DATA_W-ID_W){1'b0}}, idByte(idIdx)};
      default:    busRdData = '0;
    endcase
  end

  // R2, R4: a valid pulse always lands, even against a clear
  a_r2_event_lands: assert property (@(posedge clk) disable iff (!rstN)
    (setBits != '0) |=> ((stickyQ & $past(setBits)) == $past(setBits)));

  // R3: cleared bits without a competing pulse are gone
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClear |=>
      ((stickyQ & $past(busWrData[STICKY_W-1:0]) & ~$past(setBits)) == '0));

  // R2: without pulse or clear the sticky word holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((setBits == '0) && !strb.wrClear) |=> $stable(stickyQ));

  // R2: the hole at bit 9 stays empty
  a_r2_hole_empty: assert property (@(posedge clk) disable iff (!rstN)
    !stickyQ[9]);

  // R6: a mask write lands
  a_r6_mask_loads: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskA |=> (maskQ[0] == $past(busWrData[STATUS_W-1:0])));

endmodule

// File: rtl/mmc_stat_irq.sv
module mmc_stat_irq
  import mmc_stat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int NUM_RSP  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [WADDR_W-1:0]        busWordAddr,
  input  logic                      busWrEn,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  input  logic [STICKY_W-1:0]       evtPulse,
  input  logic [LIVE_W-1:0]         liveFlags,
  input  logic                      rspLoad,
  input  logic [NUM_RSP*DATA_W-1:0] rspWords,
  output logic                      intReqA,
  output logic                      intReqB
);

  localparam int RSP_IDX_W = $clog2(NUM_RSP);

  wrStrobeT              strb;
  rdSelT                 rdSel;
  logic [RSP_IDX_W-1:0]  rspIdx;
  logic [2:0]            idIdx;
  logic [NUM_IRQ-1:0]    irqOut;

  mmc_stat_ctrl #(
    .NUM_RSP (NUM_RSP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordAddr (busWordAddr),
    .wrEn     (busWrEn),
    .strb     (strb),
    .rdSel    (rdSel),
    .rspIdx   (rspIdx),
    .idIdx    (idIdx)
  );

  mmc_stat_path #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .NUM_RSP  (NUM_RSP)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .rspIdx    (rspIdx),
    .idIdx     (idIdx),
    .busWrData (busWrData),
    .evtPulse  (evtPulse),
    .liveFlags (liveFlags),
    .rspLoad   (rspLoad),
    .rspWords  (rspWords),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  assign intReqA = irqOut[0];
  assign intReqB = irqOut[1];

endmodule

// File: tb/test_mmc_stat_irq.sv
module test_mmc_stat_irq;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 33;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [9:0]   busWordAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [10:0]  evtPulse = '0;
  logic [10:0]  liveFlags = '0;
  logic         rspLoad = 1'b0;
  logic [127:0] rspWords = '0;
  logic         intReqA;
  logic         intReqB;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_stat_irq i_mmc_stat_irq (
    .clk         (clk),
    .rstN        (rstN),
    .busWordAddr (busWordAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .evtPulse    (evtPulse),
    .liveFlags   (liveFlags),
    .rspLoad     (rspLoad),
    .rspWords    (rspWords),
    .intReqA     (intReqA),
    .intReqB     (intReqB)
  );

  // {isWrite, requirement number, word address, data or expected value}
  localparam logic [46:0] VEC [N_VEC] = '{
    {1'b1, 4'd7, 10'd0, 32'h0000_1234}, {1'b0, 4'd7, 10'd0, 32'h0000_0034}, // R7
    {1'b1, 4'd7, 10'd1, 32'hFFFF_FFA5}, {1'b0, 4'd7, 10'd1, 32'h0000_00A5}, // R7
    {1'b1, 4'd7, 10'd2, 32'hDEAD_BEEF}, {1'b0, 4'd7, 10'd2, 32'hDEAD_BEEF}, // R7
    {1'b1, 4'd7, 10'd3, 32'h0000_0455}, {1'b0, 4'd7, 10'd3, 32'h0000_0455}, // R7
    {1'b1, 4'd6, 10'd15, 32'hFFFF_FFFF}, {1'b0, 4'd6, 10'd15, 32'h003F_FFFF}, // R6
    {1'b1, 4'd6, 10'd16, 32'h1234_5678}, {1'b0, 4'd6, 10'd16, 32'h0034_5678}, // R6
    {1'b1, 4'd6, 10'd15, 32'h0000_0000}, {1'b0, 4'd6, 10'd15, 32'h0000_0000}, // R6
    {1'b1, 4'd6, 10'd16, 32'h0000_0000}, {1'b0, 4'd6, 10'd16, 32'h0000_0000}, // R6
    {1'b1, 4'd8, 10'd5, 32'h1111_1111}, {1'b0, 4'd8, 10'd5, 32'h0000_0000}, // R8
    {1'b1, 4'd10, 10'd13, 32'hFFFF_FFFF}, {1'b0, 4'd10, 10'd13, 32'h0000_0000}, // R10
    {1'b1, 4'd10, 10'd64, 32'hFFFF_FFFF}, {1'b0, 4'd10, 10'd64, 32'h0000_0000}, // R10
    {1'b0, 4'd10, 10'd4, 32'h0000_0000}, {1'b0, 4'd10, 10'd14, 32'h0000_0000}, // R10
    {1'b0, 4'd10, 10'd0, 32'h0000_0034},                                     // R10
    {1'b0, 4'd9, 10'h3F8, 32'h81}, {1'b0, 4'd9, 10'h3F9, 32'h11},            // R9
    {1'b0, 4'd9, 10'h3FA, 32'h04}, {1'b0, 4'd9, 10'h3FB, 32'h00},
    {1'b0, 4'd9, 10'h3FC, 32'h0D}, {1'b0, 4'd9, 10'h3FD, 32'hF0},
    {1'b0, 4'd9, 10'h3FE, 32'h05}, {1'b0, 4'd9, 10'h3FF, 32'hB1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busWordAddr = a;
    busWrData = d;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input string tag, input logic [9:0] a, input logic [31:0] exp);
    busWordAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic pulseEvt(input logic [10:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRead("R1 power", 10'd0, 32'h0);
    busRead("R1 argument", 10'd2, 32'h0);
    busRead("R1 status", 10'd13, 32'h0);
    busRead("R1 maskA", 10'd15, 32'h0);
    busRead("R1 response", 10'd8, 32'h0);
    check("R1 intReqA", {31'b0, intReqA}, 32'h0);
    check("R1 intReqB", {31'b0, intReqB}, 32'h0);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][46]) begin
        busWrite(VEC[i][41:32], VEC[i][31:0]);
      end else begin
        busRead($sformatf("R%0d table entry %0d", VEC[i][45:42], i),
                VEC[i][41:32], VEC[i][31:0]);
      end
    end

    // R5: live flags reach status in the same cycle
    @(negedge clk);
    liveFlags = 11'h5A5;
    busRead("R5 live bits", 10'd13, 32'h002D_2800);

    // R2: all pulses, bit 9 stays empty; sticky holds
    pulseEvt(11'h7FF);
    busRead("R2 sticky set", 10'd13, 32'h002D_2DFF);
    repeat (3) @(negedge clk);
    busRead("R2 sticky held", 10'd13, 32'h002D_2DFF);

    // R6: per-line masks
    busWrite(10'd15, 32'h0000_0008);
    busWrite(10'd16, 32'h0000_0200);
    #1;
    check("R6 intReqA on bit3", {31'b0, intReqA}, 32'h1);
    check("R6 intReqB on hole bit9", {31'b0, intReqB}, 32'h0);

    // R3: clear low nibble only, live part untouched
    busWrite(10'd14, 32'hFFFF_F00F);
    busRead("R3 after clear", 10'd13, 32'h002D_2DF0);
    check("R3 intReqA dropped", {31'b0, intReqA}, 32'h0);

    // R6/R5: mask on a live bit follows the input
    busWrite(10'd16, 32'h0000_0800);
    #1;
    check("R6 intReqB on live bit", {31'b0, intReqB}, 32'h1);
    liveFlags = 11'h000;
    #1;
    check("R5 intReqB follows live", {31'b0, intReqB}, 32'h0);

    // R4: set wins over a same-cycle clear
    busWrite(10'd14, 32'h0000_07FF);
    busRead("R3 full clear", 10'd13, 32'h0);
    @(negedge clk);
    evtPulse = 11'h010;
    busWordAddr = 10'd14;
    busWrData = 32'h0000_07FF;
    busWrEn = 1'b1;
    @(negedge clk);
    evtPulse = '0;
    busWrEn = 1'b0;
    busRead("R4 set wins", 10'd13, 32'h0000_0010);

    // R8: response load order
    @(negedge clk);
    rspWords = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    rspLoad = 1'b1;
    @(negedge clk);
    rspLoad = 1'b0;
    busRead("R8 word0", 10'd5, 32'h1111_1111);
    busRead("R8 word1", 10'd6, 32'h2222_2222);
    busRead("R8 word3", 10'd8, 32'h4444_4444);

    // R1: reset in mid run
    busWrite(10'd15, 32'h0000_0010);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busRead("R1 status after reset", 10'd13, 32'h0);
    busRead("R1 maskA after reset", 10'd15, 32'h0);
    busRead("R1 response after reset", 10'd5, 32'h0);
    busRead("R1 power after reset", 10'd0, 32'h0);

    summary();
  end

endmodule